// File: doc/BRIEF.md
# DS3 Alarm Change Interrupt Register

This block sits behind a DS3 receive framer and turns three alarm indications into sticky change-of-state interrupt flags. On every frame-valid strobe it samples the frame's X-bits and AIC bit. A far-end receive failure (FERF) holds for a frame whose X-bits are all zero. The block also watches the framer's out-of-frame (OOF) level on every clock. A FERF flag, an AIC flag and an OOF flag are each raised when their condition starts and again when it ends.

Software reaches the block through a small read port with an address, a read strobe and a registered data output. One address is a live status register that carries the present FERF state. A second address is the interrupt status register. Reading it returns the flags that are set and clears them in the same access. The interrupt output is asserted while any flag is set whose enable bit is on.

Top module: `ds3_alarm_irq`

## Requirements
- R1: A read of address 0x11 returns the present FERF state in bit 4, with all other bits 0. FERF is 1 after a sampled frame whose X-bits are all 0, and 0 after a sampled frame with any X-bit at 1.
- R2: X-bits and the AIC bit are sampled only in cycles with frame_vld_i high. Changes at other times alter neither the FERF state nor any flag.
- R3: The first sampled frame after reset loads the FERF and AIC reference values and raises no flag. The first clock after reset loads the OOF reference the same way.
- R4: Interrupt status bit 3 (FERF change) sets when FERF goes from 0 to 1 and when it goes from 1 to 0.
- R5: Interrupt status bit 2 (AIC change) sets whenever a sampled AIC bit differs from the previously sampled one.
- R6: Interrupt status bit 1 (OOF change) sets when oof_i rises and when oof_i falls.
- R7: A read of address 0x12 returns the flags in bits 3:1, with all other bits 0, and clears those flags. Read data appears on rdata_o in the cycle after rd_i and is 0 in cycles that follow no read.
- R8: A change event in the same cycle as a clearing read leaves its flag set after that read.
- R9: irq_o is high exactly when some flag is set whose bit in IRQ_EN is 1. IRQ_EN bit 2 enables FERF, bit 1 enables AIC and bit 0 enables OOF. The default enables all three.
- R10: After reset all flags, the FERF state and rdata_o are 0, and irq_o is low.
- R11: A read of any address other than 0x11 or 0x12 returns 0 and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_vld_i | input | 1 | Strobe marking a received frame's alarm bits as valid |
| xbits_i | input | NUM_X | X-bits of the received frame |
| aic_i | input | 1 | AIC bit of the received frame |
| oof_i | input | 1 | Framer out-of-frame level |
| rd_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Read address |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds two copies of the block side by side. The first uses the default parameters, with two X-bits and all enables on. The second keeps only the AIC enable, so it shows a set flag that is masked from irq_o while the same flag still reads back. Both copies are compared on every clock against a behavioural model. Directed sequences cover FERF start and end, strobe-less input changes, OOF edges, reads of other addresses, and an event that lands in the same cycle as a clearing read.

// File: rtl/ds3_alarm_pkg.sv
package ds3_alarm_pkg;
  localparam int NUM_FLAGS     = 3;
  localparam int FLG_OOF       = 0;
  localparam int FLG_AIC       = 1;
  localparam int FLG_FERF      = 2;
  localparam int ISR_LSB       = 1;  // flags occupy isr bits 3:1
  localparam int STAT_FERF_BIT = 4;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/ds3_frame_alarm_det.sv
module ds3_frame_alarm_det #(
  parameter int NUM_X = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_vld_i,
  input  logic [NUM_X-1:0] xbits_i,
  input  logic             aic_i,
  output logic             ferf_o,
  output logic             ferf_chg_o,
  output logic             aic_chg_o
);
  logic seen_q, ferf_q, aic_q, ferf_now;

  assign ferf_now = ~|xbits_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      ferf_q <= 1'b0;
      aic_q  <= 1'b0;
    end else if (frame_vld_i) begin
      seen_q <= 1'b1;
      ferf_q <= ferf_now;
      aic_q  <= aic_i;
    end
  end

  assign ferf_chg_o = frame_vld_i & seen_q & (ferf_now ^ ferf_q);
  assign aic_chg_o  = frame_vld_i & seen_q & (aic_i ^ aic_q);
  assign ferf_o     = ferf_q;

  assert_ferf_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |=> $stable(ferf_o));
  assert_no_evt_without_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld_i |-> !(ferf_chg_o || aic_chg_o));
endmodule

// File: rtl/ds3_oof_watch.sv
module ds3_oof_watch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oof_i,
  output logic oof_chg_o
);
  logic seen_q, oof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      oof_q  <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      oof_q  <= oof_i;
    end
  end

  assign oof_chg_o = seen_q & (oof_i ^ oof_q);
endmodule

// File: rtl/ds3_sticky_flags.sv
module ds3_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (flag_q & ~clr_i) | set_i[g];  // set wins over clear
    end
    assign flags_o[g] = flag_q;

    assert_set_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flags_o[g]);
    assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !set_i[g]) |=> !flags_o[g]);
    assert_no_spurious_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flags_o[g] && !set_i[g]) |=> !flags_o[g]);
  end
endmodule

// File: rtl/ds3_alarm_irq.sv
module ds3_alarm_irq
  import ds3_alarm_pkg::*;
#(
  parameter int                 NUM_X     = 2,
  parameter int                 ADDR_W    = 8,
  parameter int                 DATA_W    = 8,
  parameter logic [ADDR_W-1:0]  STAT_ADDR = 'h11,
  parameter logic [ADDR_W-1:0]  ISR_ADDR  = 'h12,
  parameter logic [NUM_FLAGS-1:0] IRQ_EN  = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_vld_i,
  input  logic [NUM_X-1:0]  xbits_i,
  input  logic              aic_i,
  input  logic              oof_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int ISR_MSB = ISR_LSB + NUM_FLAGS - 1;

  logic       ferf, ferf_chg, aic_chg, oof_chg;
  logic       stat_hit, isr_hit;
  flag_vec_t  evt, flags;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  ds3_frame_alarm_det #(.NUM_X(NUM_X)) u_det (
    .clk_i, .rst_ni, .frame_vld_i, .xbits_i, .aic_i,
    .ferf_o(ferf), .ferf_chg_o(ferf_chg), .aic_chg_o(aic_chg)
  );

  ds3_oof_watch u_oof (.clk_i, .rst_ni, .oof_i, .oof_chg_o(oof_chg));

  always_comb begin
    evt           = '0;
    evt[FLG_FERF] = ferf_chg;
    evt[FLG_AIC]  = aic_chg;
    evt[FLG_OOF]  = oof_chg;
  end

  assign stat_hit = rd_i && (addr_i == STAT_ADDR);
  assign isr_hit  = rd_i && (addr_i == ISR_ADDR);

  ds3_sticky_flags #(.N(NUM_FLAGS)) u_flags (
    .clk_i, .rst_ni, .set_i(evt), .clr_i(isr_hit), .flags_o(flags)
  );

  always_comb begin
    rdata_d = '0;
    if (stat_hit) rdata_d[STAT_FERF_BIT]    = ferf;
    if (isr_hit)  rdata_d[ISR_MSB:ISR_LSB]  = flags;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |(flags & IRQ_EN);

  assert_status_ferf_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_hit |=> (rdata_o[STAT_FERF_BIT] == $past(ferf)));
  assert_isr_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_hit |=> (rdata_o[ISR_MSB:ISR_LSB] == $past(flags)));
  assert_quiet_when_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

// File: tb/ds3_alarm_irq_tb.sv
module ds3_alarm_irq_tb_top;
  localparam int NUM_X = 2;
  localparam logic [2:0] EN2 = 3'b010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_vld = 0, aic = 0, oof = 1, rd = 0;
  logic [NUM_X-1:0] xbits = '1;
  logic [7:0] addr = '0;
  logic [7:0] rdata, rdata2;
  logic irq, irq2;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  ds3_alarm_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(frame_vld), .xbits_i(xbits),
    .aic_i(aic), .oof_i(oof), .rd_i(rd), .addr_i(addr), .rdata_o(rdata), .irq_o(irq));

  ds3_alarm_irq #(.IRQ_EN(EN2)) dut2_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_vld_i(frame_vld), .xbits_i(xbits),
    .aic_i(aic), .oof_i(oof), .rd_i(rd), .addr_i(addr), .rdata_o(rdata2), .irq_o(irq2));

  // behavioural reference
  bit m_fseen, m_ferf, m_aic, m_oseen, m_oof;
  bit [2:0] m_flags;  // [2] ferf, [1] aic, [0] oof
  bit [7:0] m_rdata;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fseen = 0; m_ferf = 0; m_aic = 0; m_oseen = 0; m_oof = 0;
      m_flags = 0; m_rdata = 0;
    end else begin
      bit [2:0] ev;
      bit now;
      ev = 0;
      now = (xbits == 0);
      m_rdata = 0;
      if (rd && addr == 8'h11) m_rdata = {3'b0, m_ferf, 4'b0};
      if (rd && addr == 8'h12) m_rdata = {4'b0, m_flags, 1'b0};
      if (frame_vld) begin
        if (m_fseen && now != m_ferf) ev[2] = 1;
        if (m_fseen && aic != m_aic)  ev[1] = 1;
        m_fseen = 1; m_ferf = now; m_aic = aic;
      end
      if (m_oseen && oof != m_oof) ev[0] = 1;
      m_oseen = 1; m_oof = oof;
      if (rd && addr == 8'h12) m_flags = 0;
      m_flags = m_flags | ev;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison (R7 read data, R9 interrupt gating)
  always @(negedge clk) if (rst_n) begin
    chk(rdata  == m_rdata, "R7 rdata",  rdata,  m_rdata);
    chk(rdata2 == m_rdata, "R7 rdata2", rdata2, m_rdata);
    chk(irq  == |m_flags,         "R9 irq",  irq,  |m_flags);
    chk(irq2 == |(m_flags & EN2), "R9 irq2", irq2, |(m_flags & EN2));
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [NUM_X-1:0] x, input logic a);
    @(negedge clk); frame_vld = 1; xbits = x; aic = a;
    @(negedge clk); frame_vld = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(negedge clk); d = rdata; rd = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    cyc(2);
    // R10 reset state
    chk(rdata == 0 && irq == 0, "R10 reset", {rdata, irq}, 0);
    rst_n = 1;
    cyc(2);
    rd_reg(8'h12, d); chk(d == 0, "R3 oof ref no flag", d, 0);
    // R3 first frame: all-zero X-bits but no flag
    frame(2'b00, 1'b1);
    rd_reg(8'h12, d); chk(d == 0, "R3 first frame quiet", d, 0);
    rd_reg(8'h11, d); chk(d == 8'h10, "R1 ferf live", d, 8'h10);
    // R4 FERF end
    frame(2'b10, 1'b1);
    chk(irq == 1, "R4 irq after ferf end", irq, 1);
    rd_reg(8'h11, d); chk(d == 8'h00, "R1 ferf cleared", d, 0);
    rd_reg(8'h12, d); chk(d == 8'h08, "R4 ferf end flag", d, 8'h08);
    rd_reg(8'h12, d); chk(d == 8'h00, "R7 cleared by read", d, 0);
    // R4 FERF start
    frame(2'b00, 1'b1);
    rd_reg(8'h12, d); chk(d == 8'h08, "R4 ferf start flag", d, 8'h08);
    // R2 changes without strobe are ignored
    @(negedge clk); xbits = 2'b11; aic = 0;
    cyc(3);
    rd_reg(8'h11, d); chk(d == 8'h10, "R2 ferf held", d, 8'h10);
    rd_reg(8'h12, d); chk(d == 8'h00, "R2 no flags", d, 0);
    // R5 AIC change
    frame(2'b00, 1'b0);
    chk(irq2 == 1, "R9 aic enabled on dut2", irq2, 1);
    rd_reg(8'h12, d); chk(d == 8'h04, "R5 aic flag", d, 8'h04);
    frame(2'b00, 1'b0);
    rd_reg(8'h12, d); chk(d == 8'h00, "R5 same aic quiet", d, 0);
    // R6 OOF falling then rising
    @(negedge clk); oof = 0;
    @(negedge clk);
    chk(irq == 1 && irq2 == 0, "R9 oof masked on dut2", {irq, irq2}, 2'b10);
    // R11 other address returns 0 and keeps flags
    rd_reg(8'h05, d); chk(d == 0, "R11 other addr", d, 0);
    rd_reg(8'h12, d); chk(d == 8'h02, "R6 oof fall flag", d, 8'h02);
    @(negedge clk); oof = 1;
    cyc(1);
    rd_reg(8'h12, d); chk(d == 8'h02, "R6 oof rise flag", d, 8'h02);
    // R8 event coincides with clearing read
    @(negedge clk); rd = 1; addr = 8'h12; frame_vld = 1; xbits = 2'b01; aic = 1;
    @(negedge clk); d = rdata; rd = 0; frame_vld = 0;
    chk(d == 8'h00, "R8 read before event", d, 0);
    rd_reg(8'h12, d); chk(d == 8'h0c, "R8 event kept", d, 8'h0c);
    cyc(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule